// File: doc/BRIEF.md
# Timer Capture Channel Input Stage

This block is the input side of one capture channel attached to a free-running timer. It selects one of four capture sources: two external pins, a constant low and a constant high. In capture mode it watches the selected level for a programmed edge and, on a match, copies the timer count into a capture register. Edge detection runs either directly on the raw level or behind a synchronizer clocked by the timer clock. In compare mode the source selection is ignored and no capture happens.

Each capture sets a sticky flag. A capture that arrives while the flag is still set also sets a sticky overflow bit. The interrupt request leaves the block only when both the channel enable and the global enable are high. A transparent latch, open while the compare-equal strobe is high, keeps a sampled copy of the selected level. The timer counter, the compare logic and the register interface are outside this block: the count and the equal strobe arrive as inputs, and the control fields are plain input pins.

Top module: `tcap_channel`

## Requirements
- R1: In capture mode (`mode_cap_i`=1), `sel_level_o` shows the level chosen by `src_sel_i`: 0 gives `ext_a_i`, 1 gives `ext_b_i`, 2 gives constant 0 and 3 gives constant 1.
- R2: In compare mode (`mode_cap_i`=0), `src_sel_i` has no effect. `sel_level_o` follows `ext_a_i`, and no edge causes a capture or changes the flag.
- R3: `edge_sel_i` picks the capture trigger: 0 is no edge, 1 is rising, 2 is falling and 3 is both edges. An edge that is not selected leaves `cap_val_o` and `flag_o` unchanged.
- R4: With `sync_sel_i`=0, a selected edge stores into `cap_val_o` the value that `count_i` has at the first rising clock edge after the level change. The stored value is visible after that edge.
- R5: With `sync_sel_i`=1, the level passes through a two-flop synchronizer. The capture then stores the count present at the third rising clock edge after the level change, and `cap_val_o` does not change at the first two edges.
- R6: A capture sets `flag_o`. The flag stays set until a clock edge that sees `flag_clr_i`=1 with no capture in the same cycle. A capture in the same cycle as the clear wins.
- R7: A capture while `flag_o` is already 1 sets `ovf_o`. `ovf_o` stays set until a clock edge that sees `ovf_clr_i`=1, and a capture while `flag_o` is 0 does not set it.
- R8: `irq_o` is 1 exactly when `flag_o`, `chan_ie_i` and `glob_ie_i` are all 1.
- R9: While `equ_i` is 1, `eq_sample_o` follows `sel_level_o`. While `equ_i` is 0, it holds the last value it took.
- R10: `rsvd_o` always reads 0.
- R11: After a synchronous reset (`rst_n` low at a clock edge), `cap_val_o` is 0, and `flag_o` and `ovf_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| count_i | input | CNT_W (16) | Current timer count |
| equ_i | input | 1 | Compare-equal strobe, opens the sample latch |
| ext_a_i | input | 1 | External capture input A |
| ext_b_i | input | 1 | External capture input B |
| mode_cap_i | input | 1 | 1 = capture mode, 0 = compare mode |
| src_sel_i | input | 2 | Capture source select |
| edge_sel_i | input | 2 | Capture edge select |
| sync_sel_i | input | 1 | 1 = synchronized capture, 0 = direct capture |
| chan_ie_i | input | 1 | Channel interrupt enable |
| glob_ie_i | input | 1 | Global interrupt enable |
| flag_clr_i | input | 1 | Clears the capture flag |
| ovf_clr_i | input | 1 | Clears the overflow bit |
| sel_level_o | output | 1 | Live level of the selected source |
| eq_sample_o | output | 1 | Selected level latched on compare-equal |
| cap_val_o | output | CNT_W (16) | Captured count |
| flag_o | output | 1 | Capture interrupt flag |
| ovf_o | output | 1 | Capture overflow status |
| irq_o | output | 1 | Gated interrupt request |
| rsvd_o | output | 1 | Reserved status, reads 0 |

## Verification
A wrong value in the synchronizer or in the edge history shows up as a missing, extra or early capture. The capture register then holds a count off by one or two from the expected value within three clock edges of the level change, and `flag_o` rises in the wrong cycle. A stuck flag or overflow bit appears at `flag_o`, `ovf_o` and `irq_o` one edge after the clear should have acted. A latch that stays open or stays closed shows at `eq_sample_o` as soon as the selected level changes.

// File: rtl/tcap_pkg.sv
// Package: shared encodings for the timer capture channel.
// Assumes: field codes are fixed by the control register layout.
package tcap_pkg;

    typedef enum logic [1:0] {
        SRC_EXT_A = 2'd0,
        SRC_EXT_B = 2'd1,
        SRC_LOW   = 2'd2,
        SRC_HIGH  = 2'd3
    } tcap_src_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } tcap_edge_e;

endpackage

// File: rtl/tcap_src_mux.sv
// Module: tcap_src_mux
// Selects the capture source level. In compare mode the select field is
// ignored and external input A is passed through.
// Assumes: external inputs may be asynchronous; the output is combinational.
module tcap_src_mux
    import tcap_pkg::*;
(
    input  logic       ext_a_i,
    input  logic       ext_b_i,
    input  logic       mode_cap_i,
    input  logic [1:0] src_sel_i,
    output logic       level_o
);

    tcap_src_e src_q;

    // Pick the active select code; compare mode forces input A.
    always_comb begin
        src_q = mode_cap_i ? tcap_src_e'(src_sel_i) : SRC_EXT_A;
    end

    // Decode the select code into a level.
    always_comb begin
        unique case (src_q)
            SRC_EXT_A: level_o = ext_a_i;
            SRC_EXT_B: level_o = ext_b_i;
            SRC_LOW:   level_o = 1'b0;
            SRC_HIGH:  level_o = 1'b1;
            default:   level_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/tcap_edge_det.sv
// Module: tcap_edge_det
// Detects the programmed edge of the selected level, either on the raw
// level (direct path) or after a SYNC_STAGES-deep synchronizer. Both paths
// run all the time, so switching between them produces no false edge once
// the level has been steady for SYNC_STAGES+1 cycles.
// Assumes: synchronous active-low reset; enable_i gates the trigger.
module tcap_edge_det
    import tcap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level_i,
    input  logic       sync_sel_i,
    input  logic [1:0] edge_sel_i,
    input  logic       enable_i,
    output logic       trig_o
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sync_prev_q;
    logic                   raw_prev_q;
    logic                   cur_lvl;
    logic                   old_lvl;
    logic                   rise;
    logic                   fall;
    tcap_edge_e             edge_mode;

    // Build the synchronizer chain stage by stage.
    genvar gi;
    generate
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
            if (gi == 0) begin : g_first
                // First stage samples the raw level.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[gi] <= 1'b0;
                    else        sync_q[gi] <= level_i;
                end
            end else begin : g_next
                // Later stages shift the previous stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[gi] <= 1'b0;
                    else        sync_q[gi] <= sync_q[gi-1];
                end
            end
        end
    endgenerate

    // Keep one cycle of history for each path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_prev_q <= 1'b0;
            raw_prev_q  <= 1'b0;
        end else begin
            sync_prev_q <= sync_q[LAST];
            raw_prev_q  <= level_i;
        end
    end

    // Choose the path to compare.
    always_comb begin
        cur_lvl = sync_sel_i ? sync_q[LAST] : level_i;
        old_lvl = sync_sel_i ? sync_prev_q  : raw_prev_q;
        rise    = cur_lvl & ~old_lvl;
        fall    = ~cur_lvl & old_lvl;
    end

    // Apply the edge mode and the enable.
    always_comb begin
        edge_mode = tcap_edge_e'(edge_sel_i);
        unique case (edge_mode)
            EDGE_NONE: trig_o = 1'b0;
            EDGE_RISE: trig_o = enable_i & rise;
            EDGE_FALL: trig_o = enable_i & fall;
            EDGE_BOTH: trig_o = enable_i & (rise | fall);
            default:   trig_o = 1'b0;
        endcase
    end

    // R3: a trigger needs an actual change of the compared level.
    a_r3_trig_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> (cur_lvl != old_lvl));

    // R5: the synchronizer output follows its input one stage per cycle.
    a_r5_sync_shift: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sync_q[0] == $past(level_i)));

endmodule

// File: rtl/tcap_cap_regs.sv
// Module: tcap_cap_regs
// Holds the capture register, the sticky flag and the overflow bit.
// Assumes: one trigger pulse per capture; a set takes priority over a clear.
module tcap_cap_regs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             flag_clr_i,
    input  logic             ovf_clr_i,
    output logic [CNT_W-1:0] cap_val_o,
    output logic             flag_o,
    output logic             ovf_o
);

    // Store the count on a trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_val_o <= '0;
        else if (trig_i) cap_val_o <= count_i;
    end

    // Sticky flag: a trigger sets it, software clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_o <= 1'b0;
        else if (trig_i)     flag_o <= 1'b1;
        else if (flag_clr_i) flag_o <= 1'b0;
    end

    // Overflow: a trigger while the flag is still set.
    always_ff @(posedge clk) begin
        if (!rst_n)                ovf_o <= 1'b0;
        else if (trig_i && flag_o) ovf_o <= 1'b1;
        else if (ovf_clr_i)        ovf_o <= 1'b0;
    end

    // R4: the capture register changes only on a trigger.
    a_r4_cap_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_i |=> $stable(cap_val_o));

    // R6: the flag holds unless it is cleared.
    a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !flag_clr_i) |=> flag_o);

    // R7: the overflow bit rises only when the flag was already set.
    a_r7_ovf_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> $past(flag_o));

endmodule

// File: rtl/tcap_channel.sv
// Module: tcap_channel (top)
// Input side of one timer capture channel: source select, edge capture,
// flag, overflow, interrupt gating and a sample latched on compare-equal.
// Assumes: count_i and equ_i come from the timer core in the clk domain;
// the sample latch is transparent while equ_i is high.
module tcap_channel #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             equ_i,
    input  logic             ext_a_i,
    input  logic             ext_b_i,
    input  logic             mode_cap_i,
    input  logic [1:0]       src_sel_i,
    input  logic [1:0]       edge_sel_i,
    input  logic             sync_sel_i,
    input  logic             chan_ie_i,
    input  logic             glob_ie_i,
    input  logic             flag_clr_i,
    input  logic             ovf_clr_i,
    output logic             sel_level_o,
    output logic             eq_sample_o,
    output logic [CNT_W-1:0] cap_val_o,
    output logic             flag_o,
    output logic             ovf_o,
    output logic             irq_o,
    output logic             rsvd_o
);

    logic trig;

    tcap_src_mux u_mux (
        .ext_a_i    (ext_a_i),
        .ext_b_i    (ext_b_i),
        .mode_cap_i (mode_cap_i),
        .src_sel_i  (src_sel_i),
        .level_o    (sel_level_o)
    );

    tcap_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_i    (sel_level_o),
        .sync_sel_i (sync_sel_i),
        .edge_sel_i (edge_sel_i),
        .enable_i   (mode_cap_i),
        .trig_o     (trig)
    );

    tcap_cap_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_i     (trig),
        .count_i    (count_i),
        .flag_clr_i (flag_clr_i),
        .ovf_clr_i  (ovf_clr_i),
        .cap_val_o  (cap_val_o),
        .flag_o     (flag_o),
        .ovf_o      (ovf_o)
    );

    // Transparent latch: follows the selected level while equ_i is high.
    always_latch begin
        if (!rst_n)     eq_sample_o = 1'b0;
        else if (equ_i) eq_sample_o = sel_level_o;
    end

    // Gate the interrupt through the local and global enables.
    always_comb begin
        irq_o  = flag_o & chan_ie_i & glob_ie_i;
        rsvd_o = 1'b0;
    end

    // R2: compare mode never produces a capture trigger.
    a_r2_no_cap_in_compare: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_cap_i |-> !trig);

    // R8: a request needs both enables and a pending flag.
    a_r8_irq_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (glob_ie_i && chan_ie_i && flag_o));

endmodule

// File: tb/tcap_channel_bench.sv
module tcap_channel_bench;

    localparam int  CNT_W = 16;
    localparam time CYC   = 4ns;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [CNT_W-1:0] count_i;
    logic             equ_i, ext_a_i, ext_b_i, mode_cap_i;
    logic [1:0]       src_sel_i, edge_sel_i;
    logic             sync_sel_i, chan_ie_i, glob_ie_i, flag_clr_i, ovf_clr_i;
    logic             sel_level_o, eq_sample_o, flag_o, ovf_o, irq_o, rsvd_o;
    logic [CNT_W-1:0] cap_val_o;

    int n_chk = 0;
    int n_bad = 0;

    tcap_channel u_tcap_channel (
        .clk(clk), .rst_n(rst_n), .count_i(count_i), .equ_i(equ_i),
        .ext_a_i(ext_a_i), .ext_b_i(ext_b_i), .mode_cap_i(mode_cap_i),
        .src_sel_i(src_sel_i), .edge_sel_i(edge_sel_i), .sync_sel_i(sync_sel_i),
        .chan_ie_i(chan_ie_i), .glob_ie_i(glob_ie_i), .flag_clr_i(flag_clr_i),
        .ovf_clr_i(ovf_clr_i), .sel_level_o(sel_level_o), .eq_sample_o(eq_sample_o),
        .cap_val_o(cap_val_o), .flag_o(flag_o), .ovf_o(ovf_o), .irq_o(irq_o),
        .rsvd_o(rsvd_o)
    );

    always #(CYC/2) clk = ~clk;

    // The counter advances at every falling edge, so it is stable at rising edges.
    always @(negedge clk) count_i <= count_i + 16'd3;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Clear the flag and the overflow bit with one-cycle pulses.
    task automatic clear_all();
        @(negedge clk); flag_clr_i = 1'b1; ovf_clr_i = 1'b1;
        @(negedge clk); flag_clr_i = 1'b0; ovf_clr_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R11 cap", cap_val_o, 0);
        check("R11 flag", flag_o, 0);
        check("R11 ovf", ovf_o, 0);
        check("R10 rsvd", rsvd_o, 0);
    endtask

    task automatic t_src_map();
        edge_sel_i = 2'd0; mode_cap_i = 1'b1;
        ext_a_i = 1'b1; ext_b_i = 1'b0;
        for (int s = 0; s < 4; s++) begin
            src_sel_i = 2'(s); #1;
            check("R1 src a1b0", sel_level_o, (s == 0 || s == 3) ? 1 : 0);
        end
        ext_a_i = 1'b0; ext_b_i = 1'b1;
        for (int s = 0; s < 4; s++) begin
            src_sel_i = 2'(s); #1;
            check("R1 src a0b1", sel_level_o, (s == 1 || s == 3) ? 1 : 0);
        end
        check("R10 rsvd", rsvd_o, 0);
        check("R3 none no flag", flag_o, 0);
    endtask

    task automatic t_async_rise();
        logic [CNT_W-1:0] exp;
        src_sel_i = 2'd0; ext_a_i = 1'b0; sync_sel_i = 1'b0; edge_sel_i = 2'd1;
        idle(4); clear_all();
        @(negedge clk); ext_a_i = 1'b1;
        @(posedge clk); exp = count_i;
        @(negedge clk);
        check("R4 async capture", cap_val_o, exp);
        check("R6 flag set", flag_o, 1);
        check("R7 no ovf first", ovf_o, 0);
        idle(3);
        check("R6 flag sticky", flag_o, 1);
    endtask

    task automatic t_sync_fall();
        logic [CNT_W-1:0] old, exp;
        sync_sel_i = 1'b1; edge_sel_i = 2'd2; ext_a_i = 1'b1;
        idle(4); clear_all();
        old = cap_val_o;
        @(negedge clk); ext_a_i = 1'b0;
        @(posedge clk);
        @(negedge clk); check("R5 no cap edge1", cap_val_o, old);
        @(posedge clk);
        @(negedge clk); check("R5 no cap edge2", cap_val_o, old);
        @(posedge clk); exp = count_i;
        @(negedge clk);
        check("R5 sync capture", cap_val_o, exp);
        check("R6 flag set sync", flag_o, 1);
    endtask

    task automatic t_rise_ignores_fall();
        logic [CNT_W-1:0] old;
        sync_sel_i = 1'b0; edge_sel_i = 2'd1; ext_a_i = 1'b1;
        idle(4); clear_all();
        old = cap_val_o;
        @(negedge clk); ext_a_i = 1'b0;
        idle(3);
        check("R3 fall ignored cap", cap_val_o, old);
        check("R3 fall ignored flag", flag_o, 0);
    endtask

    task automatic t_both_and_ovf();
        logic [CNT_W-1:0] exp;
        sync_sel_i = 1'b0; edge_sel_i = 2'd3; ext_a_i = 1'b0;
        idle(4); clear_all();
        @(negedge clk); ext_a_i = 1'b1;
        @(posedge clk); exp = count_i;
        @(negedge clk); check("R3 both rise", cap_val_o, exp);
        check("R7 no ovf", ovf_o, 0);
        ext_a_i = 1'b0;
        @(posedge clk); exp = count_i;
        @(negedge clk); check("R3 both fall", cap_val_o, exp);
        check("R7 ovf set", ovf_o, 1);
        idle(2);
        check("R7 ovf sticky", ovf_o, 1);
        @(negedge clk); ovf_clr_i = 1'b1;
        @(negedge clk); ovf_clr_i = 1'b0;
        check("R7 ovf cleared", ovf_o, 0);
        check("R6 flag kept", flag_o, 1);
        // A capture in the same cycle as a flag clear keeps the flag set.
        flag_clr_i = 1'b1; ext_a_i = 1'b1;
        @(negedge clk); flag_clr_i = 1'b0;
        check("R6 set beats clear", flag_o, 1);
        flag_clr_i = 1'b1;
        @(negedge clk); flag_clr_i = 1'b0;
        check("R6 flag cleared", flag_o, 0);
    endtask

    task automatic t_compare_mode();
        logic [CNT_W-1:0] old;
        mode_cap_i = 1'b0; edge_sel_i = 2'd3; sync_sel_i = 1'b0;
        ext_a_i = 1'b0; ext_b_i = 1'b1; src_sel_i = 2'd3;
        idle(4); clear_all();
        #1 check("R2 level is A", sel_level_o, 0);
        old = cap_val_o;
        @(negedge clk); ext_a_i = 1'b1;
        #1 check("R2 level follows A", sel_level_o, 1);
        @(negedge clk); ext_a_i = 1'b0;
        idle(3);
        check("R2 no capture", cap_val_o, old);
        check("R2 no flag", flag_o, 0);
        mode_cap_i = 1'b1;
    endtask

    task automatic t_irq();
        sync_sel_i = 1'b0; edge_sel_i = 2'd1; src_sel_i = 2'd0; ext_a_i = 1'b0;
        idle(4); clear_all();
        @(negedge clk); ext_a_i = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            chan_ie_i = k[0]; glob_ie_i = k[1]; #1;
            check("R8 irq gate", irq_o, (k == 3) ? 1 : 0);
        end
        clear_all(); #1;
        check("R8 irq no flag", irq_o, 0);
        chan_ie_i = 1'b0; glob_ie_i = 1'b0;
    endtask

    task automatic t_eq_latch();
        edge_sel_i = 2'd0; mode_cap_i = 1'b1; src_sel_i = 2'd1; ext_b_i = 1'b0;
        @(negedge clk); equ_i = 1'b1; #1;
        check("R9 open low", eq_sample_o, 0);
        ext_b_i = 1'b1; #1;
        check("R9 open follows", eq_sample_o, 1);
        equ_i = 1'b0; #1;
        ext_b_i = 1'b0; #1;
        check("R9 closed holds", eq_sample_o, 1);
        src_sel_i = 2'd2; #1;
        check("R9 closed holds sel", eq_sample_o, 1);
        equ_i = 1'b1; #1;
        check("R9 reopen", eq_sample_o, 0);
        equ_i = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; count_i = 16'h0100; equ_i = 1'b0; ext_a_i = 1'b0; ext_b_i = 1'b0;
        mode_cap_i = 1'b1; src_sel_i = 2'd0; edge_sel_i = 2'd0; sync_sel_i = 1'b0;
        chan_ie_i = 1'b0; glob_ie_i = 1'b0; flag_clr_i = 1'b0; ovf_clr_i = 1'b0;
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_src_map();
        t_async_rise();
        t_sync_fall();
        t_rise_ignores_fall();
        t_both_and_ovf();
        t_compare_mode();
        t_irq();
        t_eq_latch();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CYC * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule